// File: doc/BRIEF.md
# Compact 8-bit Stack-Register Processor Core

This block is a small multi-cycle processor with eight 8-bit general registers and a single 256-byte memory shared by code, data and stack. Each instruction takes two clock cycles. In the first, the opcode byte and the two bytes after it are latched. In the second, the instruction executes. The highest general register doubles as the stack pointer, and the register just below it holds the result code of the last compare. Conditional jumps test that code.

A host fills memory through a byte-wide load port while it holds the core in reset. It then releases reset, and execution starts at address 0. A print instruction presents a register on an output bus for exactly one cycle. A halt instruction, or any opcode outside the supported set, freezes the core until the next reset. An unknown opcode also raises a separate flag.

Top module: `cpu8_core`

## Requirements
- R1: During reset the outputs `outValid`, `halted` and `illegal` are 0, PC is 0, registers 0 to 6 are 0 and register 7 (the stack pointer) is 0xF4.
- R2: While `rstN` is low, a high `loadWe` writes `loadData` into memory at `loadAddr` on the rising clock edge. The program then runs from address 0 after `rstN` rises.
- R3: An instruction that does not jump advances PC by opcode bits [7:6] plus one. Every instruction takes one fetch cycle followed by one execute cycle.
- R4: LDI (0x82) writes the third instruction byte into the register named by the second byte. ADD (0xA0) and MUL (0xA2) write the low 8 bits of the sum or product of registers A and B back into register A.
- R5: CMP (0xA7) compares registers A and B as unsigned values. It writes 1 into register 6 if they are equal, 2 if A is greater and 4 if A is less.
- R6: PUSH (0x45) first decrements register 7, then stores register A at the new address. POP (0x46) loads register A from the address in register 7, then increments register 7. For a POP into register 7, the loaded byte wins.
- R7: CALL (0x50) pushes PC+2 the same way PUSH does and loads PC from register A. RET (0x11) loads PC from the top of the stack and increments register 7.
- R8: JMP (0x54) loads PC from register A. JEQ (0x55) does the same only when register 6 is 1. JNE (0x56) does the same only when register 6 is 2 or 4. A jump that is not taken advances PC by 2.
- R9: PRN (0x47) drives register A on `outData` with `outValid` high for exactly one cycle, namely the cycle after the execute cycle.
- R10: HLT (0x01) sets `halted`. From then on there are no prints, register writes or memory writes until reset.
- R11: Any other opcode sets both `illegal` and `halted` and freezes the core the same way HLT does.
- R12: A register operand uses only the low 3 bits of its operand byte, so an operand of 0x0A selects register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset; the load port is live while it is low |
| loadWe | input | 1 | Load-port write enable (used only in reset) |
| loadAddr | input | 8 | Load-port byte address |
| loadData | input | 8 | Load-port byte value |
| outValid | output | 1 | One-cycle strobe for a printed value |
| outData | output | 8 | Printed register value |
| halted | output | 1 | Core stopped by HLT or by an unknown opcode |
| illegal | output | 1 | Core stopped by an unknown opcode |

## Verification
The hardest situations to reach from the ports are the subroutine round trip and the two outcomes of each conditional jump. The return address sits in memory that the ports cannot read, and a jump that is taken differs from a fall-through only through which instructions run next. The test program therefore prints the stack pointer from inside a subroutine and prints a value set there after the return. It places a print directly after each jump that must be taken, so that a wrong jump shows up as an extra or missing value in the print sequence. A behavioural reference model runs the same image and is compared with the outputs on every cycle.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam logic [7:0] OP_LDI  = 8'h82;
  localparam logic [7:0] OP_PRN  = 8'h47;
  localparam logic [7:0] OP_MUL  = 8'hA2;
  localparam logic [7:0] OP_HLT  = 8'h01;
  localparam logic [7:0] OP_PUSH = 8'h45;
  localparam logic [7:0] OP_POP  = 8'h46;
  localparam logic [7:0] OP_CALL = 8'h50;
  localparam logic [7:0] OP_RET  = 8'h11;
  localparam logic [7:0] OP_ADD  = 8'hA0;
  localparam logic [7:0] OP_CMP  = 8'hA7;
  localparam logic [7:0] OP_JMP  = 8'h54;
  localparam logic [7:0] OP_JEQ  = 8'h55;
  localparam logic [7:0] OP_JNE  = 8'h56;

  typedef enum logic [1:0] {WB_IMM, WB_ADD, WB_MUL, WB_MEM} wbSel_e;
  typedef enum logic [1:0] {PC_HOLD, PC_STEP, PC_REG, PC_MEM} pcSel_e;
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_STOP} coreState_e;

  typedef struct packed {
    logic   fetch;
    logic   wrReg;
    wbSel_e wbSel;
    logic   wrFlag;
    logic   spDown;
    logic   spUp;
    logic   memWr;
    logic   pushRet;
    pcSel_e pcSel;
    logic   emit;
  } ctrlStrobe_t;

endpackage

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] flagVal,
  output ctrlStrobe_t       cs,
  output logic              halted,
  output logic              illegal
);

  coreState_e state;
  logic flagEq, flagNe, stopNow, badOp;

  assign flagEq = (flagVal == DATA_W'(1));
  assign flagNe = (flagVal == DATA_W'(2)) || (flagVal == DATA_W'(4));

  always_comb begin
    cs      = '0;
    cs.pcSel = PC_HOLD;
    cs.wbSel = WB_IMM;
    stopNow = 1'b0;
    badOp   = 1'b0;
    unique case (state)
      ST_FETCH: cs.fetch = 1'b1;
      ST_EXEC: begin
        cs.pcSel = PC_STEP;
        case (opcode)
          OP_LDI:  begin cs.wrReg = 1'b1; cs.wbSel = WB_IMM; end
          OP_ADD:  begin cs.wrReg = 1'b1; cs.wbSel = WB_ADD; end
          OP_MUL:  begin cs.wrReg = 1'b1; cs.wbSel = WB_MUL; end
          OP_CMP:  cs.wrFlag = 1'b1;
          OP_PUSH: begin cs.spDown = 1'b1; cs.memWr = 1'b1; end
          OP_POP:  begin cs.wrReg = 1'b1; cs.wbSel = WB_MEM; cs.spUp = 1'b1; end
          OP_CALL: begin
            cs.spDown = 1'b1; cs.memWr = 1'b1; cs.pushRet = 1'b1;
            cs.pcSel = PC_REG;
          end
          OP_RET:  begin cs.spUp = 1'b1; cs.pcSel = PC_MEM; end
          OP_JMP:  cs.pcSel = PC_REG;
          OP_JEQ:  cs.pcSel = flagEq ? PC_REG : PC_STEP;
          OP_JNE:  cs.pcSel = flagNe ? PC_REG : PC_STEP;
          OP_PRN:  cs.emit = 1'b1;
          OP_HLT:  begin cs.pcSel = PC_HOLD; stopNow = 1'b1; end
          default: begin cs.pcSel = PC_HOLD; stopNow = 1'b1; badOp = 1'b1; end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_FETCH;
      halted  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          state <= stopNow ? ST_STOP : ST_FETCH;
          if (stopNow) halted  <= 1'b1;
          if (badOp)   illegal <= 1'b1;
        end
        default: state <= ST_STOP;
      endcase
    end
  end

endmodule

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
  import cpu8_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 8,
  parameter int          REG_CNT  = 8,
  parameter logic [DATA_W-1:0] SP_RESET = 8'hF4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       cs,
  input  logic              loadWe,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic [7:0]        opcode,
  output logic [DATA_W-1:0] flagVal,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int RIDX_W    = $clog2(REG_CNT);
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int SP_IDX    = REG_CNT - 1;
  localparam int FLAG_IDX  = REG_CNT - 2;

  logic [DATA_W-1:0] mem  [MEM_DEPTH];
  logic [DATA_W-1:0] regs [REG_CNT];
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, opA, opB;

  logic [RIDX_W-1:0] aIdx, bIdx;
  logic [DATA_W-1:0] regA, regB, spVal, spMinus, spPlus;
  logic [DATA_W-1:0] wbData, cmpCode, popData, memWrData;
  logic [ADDR_W-1:0] pcStep, pcRet;
  logic              unusedOpBits;

  assign aIdx    = opA[RIDX_W-1:0];
  assign bIdx    = opB[RIDX_W-1:0];
  assign regA    = regs[aIdx];
  assign regB    = regs[bIdx];
  assign spVal   = regs[SP_IDX];
  assign spMinus = spVal - DATA_W'(1);
  assign spPlus  = spVal + DATA_W'(1);
  assign popData = mem[ADDR_W'(spVal)];
  assign pcStep  = pc + ADDR_W'(ir[7:6]) + ADDR_W'(1);
  assign pcRet   = pc + ADDR_W'(2);
  assign memWrData = cs.pushRet ? DATA_W'(pcRet) : regA;
  assign unusedOpBits = ^opA[DATA_W-1:RIDX_W];

  assign opcode  = ir[7:0];
  assign flagVal = regs[FLAG_IDX];

  always_comb begin
    if (regA == regB)     cmpCode = DATA_W'(1);
    else if (regA > regB) cmpCode = DATA_W'(2);
    else                  cmpCode = DATA_W'(4);
  end

  always_comb begin
    unique case (cs.wbSel)
      WB_IMM:  wbData = opB;
      WB_ADD:  wbData = regA + regB;
      WB_MUL:  wbData = regA * regB;
      default: wbData = popData;
    endcase
  end

  // Memory: host load port in reset, stack writes while running.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (loadWe) mem[loadAddr] <= loadData;
    end else if (cs.memWr) begin
      mem[ADDR_W'(spMinus)] <= memWrData;
    end
  end

  // Register file: operand write wins over flag and stack-pointer updates.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++)
        regs[i] <= (i == SP_IDX) ? SP_RESET : '0;
    end else begin
      for (int i = 0; i < REG_CNT; i++) begin
        if (cs.wrReg && (aIdx == RIDX_W'(i)))
          regs[i] <= wbData;
        else if (cs.wrFlag && (i == FLAG_IDX))
          regs[i] <= cmpCode;
        else if (cs.spDown && (i == SP_IDX))
          regs[i] <= spMinus;
        else if (cs.spUp && (i == SP_IDX))
          regs[i] <= spPlus;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      ir       <= '0;
      opA      <= '0;
      opB      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= cs.emit;
      if (cs.emit) outData <= regA;
      if (cs.fetch) begin
        ir  <= mem[pc];
        opA <= mem[pc + ADDR_W'(1)];
        opB <= mem[pc + ADDR_W'(2)];
      end
      unique case (cs.pcSel)
        PC_STEP: pc <= pcStep;
        PC_REG:  pc <= ADDR_W'(regA);
        PC_MEM:  pc <= ADDR_W'(popData);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int REG_CNT = 8,
  parameter logic [DATA_W-1:0] SP_RESET = 8'hF4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadWe,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              halted,
  output logic              illegal
);

  ctrlStrobe_t       cs;
  logic [7:0]        opcode;
  logic [DATA_W-1:0] flagVal;

  cpu8_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .flagVal (flagVal),
    .cs      (cs),
    .halted  (halted),
    .illegal (illegal)
  );

  cpu8_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .REG_CNT  (REG_CNT),
    .SP_RESET (SP_RESET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cs       (cs),
    .loadWe   (loadWe),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .opcode   (opcode),
    .flagVal  (flagVal),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk (
  input logic clk,
  input logic rstN,
  input logic outValid,
  input logic halted,
  input logic illegal
);

  // R9
  print_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R10
  halt_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !outValid);

  // R11
  illegal_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> halted);

  // R11
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> illegal);

endmodule

bind cpu8_core cpu8_core_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .halted   (halted),
  .illegal  (illegal)
);

// File: tb/cpu8_core_bench.sv
module cpu8_core_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadWe = 1'b0;
  logic [7:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic       outValid;
  logic [7:0] outData;
  logic       halted;
  logic       illegal;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cpu8_core u_cpu8_core (
    .clk(clk), .rstN(rstN), .loadWe(loadWe), .loadAddr(loadAddr),
    .loadData(loadData), .outValid(outValid), .outData(outData),
    .halted(halted), .illegal(illegal)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] img [256];
  logic [7:0] mMem [256];
  logic [7:0] mReg [8];
  logic [7:0] mPc, mIr, mA, mB;
  bit         mExec, mHalt, mBad, mValid;
  logic [7:0] mData;
  int         imgPtr;

  task automatic put(input logic [7:0] b);
    img[imgPtr[7:0]] = b;
    imgPtr++;
  endtask

  task automatic modelReset();
    for (int i = 0; i < 256; i++) mMem[i] = img[i];
    for (int i = 0; i < 8; i++) mReg[i] = 8'h00;
    mReg[7] = 8'hF4;
    mPc = 0; mIr = 0; mA = 0; mB = 0;
    mExec = 0; mHalt = 0; mBad = 0; mValid = 0; mData = 0;
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      mValid = 0;
      if (!mHalt) begin
        if (!mExec) begin
          mIr = mMem[mPc]; mA = mMem[8'(mPc + 1)]; mB = mMem[8'(mPc + 2)];
          mExec = 1;
        end else begin
          int a, b;
          logic [7:0] va, vb, nextPc, t;
          a = int'(mA[2:0]); b = int'(mB[2:0]);
          va = mReg[a]; vb = mReg[b];
          nextPc = 8'(mPc + {6'd0, mIr[7:6]} + 8'd1);
          case (mIr)
            8'h82: mReg[a] = mB;
            8'hA0: mReg[a] = 8'(va + vb);
            8'hA2: mReg[a] = 8'(int'(va) * int'(vb));
            8'hA7: mReg[6] = (va == vb) ? 8'd1 : ((va > vb) ? 8'd2 : 8'd4);
            8'h45: begin mReg[7] = mReg[7] - 1; mMem[mReg[7]] = va; end
            8'h46: begin t = mMem[mReg[7]]; mReg[7] = mReg[7] + 1; mReg[a] = t; end
            8'h50: begin
              mReg[7] = mReg[7] - 1; mMem[mReg[7]] = 8'(mPc + 2); nextPc = va;
            end
            8'h11: begin nextPc = mMem[mReg[7]]; mReg[7] = mReg[7] + 1; end
            8'h54: nextPc = va;
            8'h55: if (mReg[6] == 1) nextPc = va;
            8'h56: if (mReg[6] == 2 || mReg[6] == 4) nextPc = va;
            8'h47: begin mValid = 1; mData = va; end
            8'h01: begin mHalt = 1; nextPc = mPc; end
            default: begin mHalt = 1; mBad = 1; nextPc = mPc; end
          endcase
          mPc = nextPc;
          mExec = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the edge.
  bit compareOn = 0;
  always @(negedge clk) begin
    if (compareOn && rstN) begin
      check(outValid == mValid, "R9 model strobe", outValid, mValid);
      if (mValid) check(outData == mData, "R9 model data", outData, mData);
      check(halted == mHalt, "R10 model halted", halted, mHalt);
      check(illegal == mBad, "R11 model illegal", illegal, mBad);
    end
  end

  // Expected print sequence, written from the requirements.
  int expVal[$];
  string expTag[$];
  int seen;
  always @(negedge clk) begin
    if (rstN && outValid) begin
      seen++;
      if (expVal.size() == 0) check(0, "R10 extra print", outData, -1);
      else begin
        int e; string tg;
        e = expVal.pop_front(); tg = expTag.pop_front();
        check(outData == e[7:0], tg, outData, e);
      end
    end
  end

  task automatic loadAndRun(input int maxCycles);
    rstN = 0;
    compareOn = 0;
    @(negedge clk);
    check(!outValid && !halted && !illegal, "R1 reset outputs", {outValid, halted, illegal}, 0);
    for (int i = 0; i < 256; i++) begin
      loadWe = 1; loadAddr = 8'(i); loadData = img[i];
      @(negedge clk);
    end
    loadWe = 0;
    modelReset();
    compareOn = 1;
    seen = 0;
    rstN = 1;
    for (int c = 0; c < maxCycles && !halted; c++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // ---------------- program 1 ----------------
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    imgPtr = 0;
    put(8'h82); put(8'h00); put(8'd8);        // 0  LDI R0,8
    put(8'h82); put(8'h01); put(8'd9);        // 3  LDI R1,9
    put(8'hA2); put(8'h00); put(8'h01);       // 6  MUL -> 72
    put(8'h47); put(8'h00);                   // 9  PRN R0
    put(8'hA0); put(8'h00); put(8'h01);       // 11 ADD -> 81
    put(8'h47); put(8'h00);                   // 14 PRN R0
    put(8'h82); put(8'h02); put(8'd200);      // 16 LDI R2,200
    put(8'hA0); put(8'h02); put(8'h02);       // 19 ADD -> 144
    put(8'h47); put(8'h0A);                   // 22 PRN R2 via 0x0A
    put(8'hA7); put(8'h00); put(8'h01);       // 24 CMP 81,9 -> 2
    put(8'h47); put(8'h06);                   // 27 PRN R6
    put(8'h45); put(8'h00);                   // 29 PUSH R0
    put(8'h46); put(8'h03);                   // 31 POP R3
    put(8'h47); put(8'h03);                   // 33 PRN R3
    put(8'h47); put(8'h07);                   // 35 PRN R7
    put(8'h82); put(8'h04); put(8'h80);       // 37 LDI R4,0x80
    put(8'h50); put(8'h04);                   // 40 CALL R4
    put(8'h47); put(8'h05);                   // 42 PRN R5
    put(8'hA7); put(8'h05); put(8'h05);       // 44 CMP equal -> 1
    put(8'h82); put(8'h04); put(8'd54);       // 47 LDI R4,54
    put(8'h55); put(8'h04);                   // 50 JEQ taken
    put(8'h47); put(8'h00);                   // 52 skipped
    put(8'h56); put(8'h04);                   // 54 JNE not taken
    put(8'hA7); put(8'h01); put(8'h00);       // 56 CMP 9,81 -> 4
    put(8'h82); put(8'h04); put(8'd66);       // 59 LDI R4,66
    put(8'h56); put(8'h04);                   // 62 JNE taken
    put(8'h47); put(8'h00);                   // 64 skipped
    put(8'h82); put(8'h04); put(8'd72);       // 66 LDI R4,72
    put(8'h54); put(8'h04);                   // 69 JMP
    put(8'h01);                               // 71 skipped HLT
    put(8'h47); put(8'h06);                   // 72 PRN R6
    put(8'h01);                               // 74 HLT
    put(8'h47); put(8'h00);                   // 75 never runs
    imgPtr = 8'h80;
    put(8'h82); put(8'h05); put(8'h33);       // sub: LDI R5,0x33
    put(8'h47); put(8'h07);                   //      PRN R7
    put(8'h11);                               //      RET

    expVal = {72, 81, 144, 2, 81, 244, 243, 51, 4};
    expTag = {"R2 R4 mul", "R4 add", "R12 R4 trunc", "R5 greater", "R6 push/pop",
              "R1 R6 sp", "R7 call sp", "R7 ret", "R8 R3 R5 jumps"};
    loadAndRun(2000);
    check(expVal.size() == 0, "R8 R10 print count", 9 - expVal.size(), 9);
    check(halted == 1, "R10 halted", halted, 1);
    check(illegal == 0, "R10 not illegal", illegal, 0);

    // ---------------- program 2: unknown opcode ----------------
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    imgPtr = 0;
    put(8'h47); put(8'h07);                   // PRN R7
    put(8'hFF);                               // unknown
    put(8'h47); put(8'h07);                   // never runs
    expVal = {244};
    expTag = {"R1 R3 restart"};
    loadAndRun(200);
    check(expVal.size() == 0 && seen == 1, "R11 prints", seen, 1);
    check(illegal == 1, "R11 illegal", illegal, 1);
    check(halted == 1, "R11 halted", halted, 1);

    summary();
    $finish;
  end

endmodule